// File: doc/BRIEF.md
# PLL Control and Lock-Interrupt Logic

This block is the digital control side of a clock-generator PLL. A CPU reaches it through a small byte-wide register file. Through that file it sets the reference division factor, turns the PLL on, enables automatic bandwidth mode and the interrupt, and picks the output clock source. The analog loop sits outside the block and returns a raw lock indication. The block synchronises that signal and latches a flag on every lock transition. It raises an interrupt request when the flag and the enable are both set.

All logic runs on one system clock. The reference clock and the VCO clock enter as single-cycle enable strobes, `ref_en` and `vco_en`. The reference divider produces one `div_tick` strobe per R reference strobes. The output strobe `out_en` follows either the reference strobe or the VCO strobe divided by two.

Top module: `pll_ctl`

## Requirements
- R1: After reset, address 0 (control) and address 1 (mode) read 0x00, address 2 (divider) reads 0x01, and `irq` and `out_en` are low.
- R2: The divider field is bits 3:0 of address 2. Bits 7:4 always read zero, so writing 0xFF reads back 0x0F.
- R3: A write to address 2 is ignored while the PLL-on bit (address 0, bit 5) is 1.
- R4: While `ref_en` is high, `div_tick` pulses once every R strobes, where R is the divider field. R = 0 gives the same period as R = 1. Without `ref_en` no tick is produced.
- R5: A new divider value takes effect only after the tick that ends the count in progress.
- R6: With auto mode (address 1, bit 7) set, both a rise and a fall of `lock_in` set the flag (address 0, bit 6). The flag becomes visible three clock edges after the input changes. The synchronised lock level reads on address 1, bit 6.
- R7: The flag sets whatever the interrupt-enable bit (address 0, bit 7) holds. `irq` is high only when both the flag and the enable are 1.
- R8: With auto mode clear, the flag reads 0, `irq` stays low, and lock changes do not set the flag.
- R9: Writing 1 to address 0, bit 6 clears the flag. Writing 0 there leaves it unchanged. A lock change in the same cycle as the clear leaves the flag set.
- R10: With the base-clock select bit (address 0, bit 4) clear, `out_en` follows `ref_en`. With it set, `out_en` pulses on every second `vco_en` strobe, whatever the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| ref_en | input | 1 | Reference clock strobe |
| vco_en | input | 1 | VCO clock strobe |
| lock_in | input | 1 | Raw lock indication from the analog detector |
| div_tick | output | 1 | Divided reference strobe |
| out_en | output | 1 | Selected output clock strobe |
| irq | output | 1 | Interrupt request |

## Verification
Register writes take effect at the edge that ends the write cycle. Read data is combinational, so the scoreboard compares it at the falling edge of the read cycle. The lock level appears two edges after `lock_in` changes and the flag appears on the third. The bench waits at least that long, except in the set-wins case, where it times the W1C write into the exact cycle in which the change pulse is high. `div_tick` and `out_en` follow their input strobes in the same cycle. The bench therefore records the cycle number of each tick at falling edges and compares the spacing between ticks, not absolute times.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;

   typedef enum logic [1:0] {
      RA_CTRL  = 2'd0,
      RA_MODE  = 2'd1,
      RA_RDIV  = 2'd2,
      RA_SPARE = 2'd3
   } reg_addr_e;

   localparam int CTRL_IE   = 7;
   localparam int CTRL_FLAG = 6;
   localparam int CTRL_ON   = 5;
   localparam int CTRL_BCS  = 4;
   localparam int MODE_AUTO = 7;
   localparam int MODE_LOCK = 6;

endpackage

// File: rtl/pll_ctl_lock_sync.sv
module pll_ctl_lock_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_in,
   output logic lock_s,
   output logic lock_chg
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pll_ctl_lock_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sr_q   <= {sr_q[STAGES-2:0], lock_in};
         prev_q <= sr_q[STAGES-1];
      end
   end

   assign lock_s   = sr_q[STAGES-1];
   assign lock_chg = lock_s ^ prev_q;

   // R6: a change pulse only when the synchronised level really moved
   a_r6_chg_on_move: assert property (@(posedge clk) disable iff (!rst_n)
      lock_chg |-> (lock_s != $past(lock_s)));

   // R6: the output level is the value the previous stage held one edge earlier
   a_r6_chain_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_s != $past(lock_s)) |-> (lock_s == $past(sr_q[STAGES-2])));

endmodule

// File: rtl/pll_ctl_refdiv.sv
module pll_ctl_refdiv #(
   parameter int RDS_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_en,
   input  logic [RDS_W-1:0] rds,
   output logic             tick
);
   if (RDS_W < 1) begin : g_bad_w
      $error("pll_ctl_refdiv: RDS_W must be positive");
   end

   logic [RDS_W-1:0] cnt_q;
   logic [RDS_W-1:0] reload;

   always_comb begin
      if (rds == '0) reload = '0;
      else           reload = rds - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (ref_en) begin
         if (cnt_q == '0) cnt_q <= reload;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign tick = ref_en && (cnt_q == '0);

   // R4: between terminal counts the counter steps down by one per strobe
   a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R4: no strobe, no movement
   a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_en |=> $stable(cnt_q));

endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
   import pll_ctl_pkg::*;
#(
   parameter int DW    = 8,
   parameter int RDS_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   input  logic             lock_s,
   input  logic             lock_chg,
   output logic [RDS_W-1:0] rds,
   output logic             bcs,
   output logic             irq
);
   if (DW < 8 || RDS_W >= DW) begin : g_bad_w
      $error("pll_ctl_regs: need DW >= 8 and RDS_W < DW");
   end

   reg_addr_e        a;
   logic             ie_q, flag_q, on_q, bcs_q, auto_q;
   logic [RDS_W-1:0] rds_q;
   logic             wr_ctrl, wr_mode, wr_rdiv;

   assign a       = reg_addr_e'(addr);
   assign wr_ctrl = wr_en && (a == RA_CTRL);
   assign wr_mode = wr_en && (a == RA_MODE);
   assign wr_rdiv = wr_en && (a == RA_RDIV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         on_q   <= 1'b0;
         bcs_q  <= 1'b0;
         auto_q <= 1'b0;
         rds_q  <= RDS_W'(1);
      end else begin
         if (wr_ctrl) begin
            ie_q  <= wdata[CTRL_IE];
            on_q  <= wdata[CTRL_ON];
            bcs_q <= wdata[CTRL_BCS];
         end
         if (wr_mode) auto_q <= wdata[MODE_AUTO];
         if (wr_rdiv && !on_q) rds_q <= wdata[RDS_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           flag_q <= 1'b0;
      else if (!auto_q)                     flag_q <= 1'b0;
      else if (lock_chg)                    flag_q <= 1'b1;
      else if (wr_ctrl && wdata[CTRL_FLAG]) flag_q <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      unique case (a)
         RA_CTRL: begin
            rdata[CTRL_IE]   = ie_q;
            rdata[CTRL_FLAG] = flag_q && auto_q;
            rdata[CTRL_ON]   = on_q;
            rdata[CTRL_BCS]  = bcs_q;
         end
         RA_MODE: begin
            rdata[MODE_AUTO] = auto_q;
            rdata[MODE_LOCK] = lock_s;
         end
         RA_RDIV:  rdata[RDS_W-1:0] = rds_q;
         RA_SPARE: rdata = '0;
      endcase
   end

   assign rds = rds_q;
   assign bcs = bcs_q;
   assign irq = ie_q && flag_q && auto_q;

   // R3: the divider field is frozen against writes while the PLL is on
   a_r3_rdiv_protected: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rdiv && on_q) |=> $stable(rds_q));

   // R9: a lock change beats a same-cycle clear
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_q && lock_chg) |=> flag_q);

   // R9: writing one with no competing change clears the flag
   a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_q && !lock_chg && wr_ctrl && wdata[CTRL_FLAG]) |=> !flag_q);

   // R8: leaving auto mode empties the flag by the next edge
   a_r8_flag_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_q |=> !flag_q);

endmodule

// File: rtl/pll_ctl.sv
module pll_ctl
   import pll_ctl_pkg::*;
#(
   parameter int DW          = 8,
   parameter int RDS_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int VCO_DIV     = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [1:0]    bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          ref_en,
   input  logic          vco_en,
   input  logic          lock_in,
   output logic          div_tick,
   output logic          out_en,
   output logic          irq
);
   if (VCO_DIV < 1) begin : g_bad_div
      $error("pll_ctl: VCO_DIV must be positive");
   end

   localparam int PW = (VCO_DIV > 2) ? $clog2(VCO_DIV) : 1;

   logic             lock_s, lock_chg, bcs_w, vco_tick;
   logic [RDS_W-1:0] rds_w;

   pll_ctl_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .lock_in(lock_in),
      .lock_s(lock_s), .lock_chg(lock_chg));

   pll_ctl_regs #(.DW(DW), .RDS_W(RDS_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .lock_s(lock_s),
      .lock_chg(lock_chg), .rds(rds_w), .bcs(bcs_w), .irq(irq));

   pll_ctl_refdiv #(.RDS_W(RDS_W)) u_div (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .rds(rds_w), .tick(div_tick));

   if (VCO_DIV == 1) begin : g_vco_pass
      assign vco_tick = vco_en;
   end else begin : g_vco_pre
      logic [PW-1:0] pc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pc_q <= '0;
         else if (vco_en) pc_q <= (pc_q == PW'(VCO_DIV-1)) ? '0 : pc_q + 1'b1;
      end
      assign vco_tick = vco_en && (pc_q == PW'(VCO_DIV-1));
   end

   assign out_en = bcs_w ? vco_tick : ref_en;

   // R10: the divided VCO path never yields two strobes in a row
   a_r10_vco_spaced: assert property (@(posedge clk) disable iff (!rst_n)
      (VCO_DIV > 1 && bcs_w && out_en) |=> (!out_en || !bcs_w));

   // R2: upper bits of the divider register read as zero
   a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == RA_RDIV) |-> (bus_rdata[DW-1:RDS_W] == '0));

endmodule

// File: tb/pll_ctl_test.sv
`timescale 1ns/1ps
module pll_ctl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       ref_en = 1'b0, vco_en = 1'b0, lock_in = 1'b0;
   logic       div_tick, out_en, irq;
   logic       rd_stb = 1'b0;

   always #10 clk = ~clk;

   pll_ctl uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_en(ref_en),
      .vco_en(vco_en), .lock_in(lock_in), .div_tick(div_tick),
      .out_en(out_en), .irq(irq));

   int n_chk = 0, n_fail = 0, cyc = 0, outs = 0;
   int ticks[$];

   typedef struct { string tag; logic [7:0] exp; } item_t;
   item_t sb[$];

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
      item_t it;
      it.tag = tag; it.exp = exp;
      @(posedge clk); #1;
      bus_addr = a; rd_stb = 1'b1;
      sb.push_back(it);
      @(posedge clk); #1;
      rd_stb = 1'b0;
   endtask

   // monitor: compares read data with the scoreboard at the falling edge
   always @(negedge clk) begin
      item_t it;
      cyc++;
      if (div_tick) ticks.push_back(cyc);
      if (out_en) outs++;
      if (rd_stb) begin
         it = sb.pop_front();
         check(it.tag, int'(bus_rdata), int'(it.exp));
      end
   end

   task automatic wait_cycles(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic measure(logic [7:0] r, int gap, string tag);
      wr(2'd2, r);
      @(posedge clk); #1;
      ticks.delete();
      ref_en = 1'b1;
      wait_cycles(50);
      ref_en = 1'b0;
      check({tag, " tick count>=3"}, int'(ticks.size() >= 3), 1);
      if (ticks.size() >= 3)
         check({tag, " period"}, ticks[ticks.size()-1] - ticks[ticks.size()-2], gap);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int t;
      wait_cycles(3);
      rst_n = 1'b1;
      wait_cycles(1);

      // R1 reset state
      rd(2'd0, 8'h00, "R1 ctrl");
      rd(2'd1, 8'h00, "R1 mode");
      rd(2'd2, 8'h01, "R1 rdiv");
      @(negedge clk);
      check("R1 irq", int'(irq), 0);
      check("R1 out_en", int'(out_en), 0);

      // R2 upper bits
      wr(2'd2, 8'hFF);
      rd(2'd2, 8'h0F, "R2 upper zero");

      // R4 periods, zero behaves as one
      measure(8'd0, 1, "R4 R=0");
      measure(8'd1, 1, "R4 R=1");
      measure(8'd15, 15, "R4 R=15");
      ticks.delete();
      wait_cycles(10);
      check("R4 no ref_en no tick", ticks.size(), 0);

      // R3 write protection
      wr(2'd0, 8'h20);
      wr(2'd2, 8'h07);
      rd(2'd2, 8'h0F, "R3 protected");
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h07);
      rd(2'd2, 8'h07, "R3 writable when off");

      // R5 reload only at terminal count
      wr(2'd2, 8'd15);
      @(posedge clk); #1;
      ref_en = 1'b1;
      wait_cycles(20);
      ticks.delete();
      do @(negedge clk); while (ticks.size() == 0);
      t = ticks[0];
      wr(2'd2, 8'd2);
      wait_cycles(25);
      ref_en = 1'b0;
      check("R5 old count finishes", ticks[1], t + 15);
      check("R5 new period", ticks[2], t + 17);

      // R6/R7 lock rise with interrupt disabled
      wr(2'd1, 8'h80);
      @(posedge clk); #1;
      bus_addr = 2'd0;
      lock_in = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      check("R6 flag not yet after 2 edges", int'(bus_rdata[6]), 0);
      @(negedge clk);
      check("R6 flag after 3 edges", int'(bus_rdata[6]), 1);
      check("R7 no irq when disabled", int'(irq), 0);
      rd(2'd1, 8'hC0, "R6 lock level");
      wr(2'd0, 8'h80);
      @(negedge clk);
      check("R7 irq with enable", int'(irq), 1);
      rd(2'd0, 8'hC0, "R9 write 0 keeps flag");
      wr(2'd0, 8'hC0);
      rd(2'd0, 8'h80, "R9 W1C clears");
      @(negedge clk);
      check("R9 irq gone", int'(irq), 0);

      // R6 falling lock also sets the flag
      @(posedge clk); #1;
      lock_in = 1'b0;
      wait_cycles(4);
      rd(2'd0, 8'hC0, "R6 fall sets flag");

      // R9 set wins over same-cycle clear
      @(posedge clk); #1;
      lock_in = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'hC0;
      @(posedge clk); #1;
      bus_wr = 1'b0;
      rd(2'd0, 8'hC0, "R9 set wins");

      // R8 manual mode
      wr(2'd1, 8'h00);
      rd(2'd0, 8'h80, "R8 flag reads zero");
      @(negedge clk);
      check("R8 irq low", int'(irq), 0);
      @(posedge clk); #1;
      lock_in = 1'b0;
      wait_cycles(5);
      wr(2'd1, 8'h80);
      rd(2'd0, 8'h80, "R8 change ignored");
      rd(2'd1, 8'h80, "R8 lock level low");

      // R10 base clock select, unlocked
      wr(2'd0, 8'h10);
      @(posedge clk); #1;
      outs = 0; vco_en = 1'b1;
      wait_cycles(6);
      vco_en = 1'b0;
      check("R10 vco/2 pulses", outs, 3);
      outs = 0; ref_en = 1'b1;
      wait_cycles(4);
      ref_en = 1'b0;
      check("R10 ref ignored when bcs", outs, 0);
      wr(2'd0, 8'h00);
      @(posedge clk); #1;
      outs = 0; ref_en = 1'b1;
      wait_cycles(4);
      ref_en = 1'b0;
      check("R10 ref path", outs, 4);
      outs = 0; vco_en = 1'b1;
      wait_cycles(4);
      vco_en = 1'b0;
      check("R10 vco ignored when ref", outs, 0);

      wait_cycles(2);
      finish_run();
   end

endmodule